// File: doc/BRIEF.md
# Microprogrammed Multicycle Control Sequencer

This block drives the control lines of a multicycle 32-bit load/store datapath. Each state of the control is one microinstruction held in a small combinational microcode store. A microprogram counter addresses that store. Every cycle the addressed microinstruction sets the datapath strobes and selects the next address. The next address is the counter plus one, zero (instruction fetch), or the result of one of two opcode-indexed dispatch lookups.

The opcode is bits 31 to 26 of the instruction register, and it enters on `opcode_i`. The microword has seven fields, and no two fields drive the same signal: ALU operation, first ALU source, second ALU source, register-file control, memory control, PC control and sequencing. The current microprogram address is brought out on `upc_o` so that the state sequence can be observed.

Top module: `mc_ctrl_seq`

## Requirements
- R1: While `rst_ni` is low, `upc_o` is 0 and the fetch control word is driven.
- R2: At address 0 (fetch), the outputs are pc_wr=1, mem_rd=1, ir_wr=1, iord=0, alu_src_a=0, alu_src_b=01, alu_op=00 and pc_src=00, and every other strobe is 0. The next address is 1.
- R3: At address 1 (decode), the outputs are alu_src_a=0, alu_src_b=11 and alu_op=00, with no strobes. The next address is looked up from the opcode: 6'h00 (register-register) goes to 6, 6'h02 (jump) goes to 9, 6'h04 (branch-equal) goes to 8, and 6'h23 (load) and 6'h2B (store) go to 2.
- R4: A load walks addresses 1, 2, 3, 4, 0. Address 2 drives alu_src_a=1 and alu_src_b=10 and uses the second lookup, which sends a load to 3. Address 3 drives mem_rd=1 and iord=1. Address 4 drives reg_wr=1, mem_to_reg=1 and reg_dst=0.
- R5: A store walks addresses 1, 2, 5, 0. The second lookup sends a store to 5. Address 5 drives mem_wr=1 and iord=1.
- R6: A register-register instruction walks addresses 1, 6, 7, 0. Address 6 drives alu_src_a=1, alu_src_b=00 and alu_op=10. Address 7 drives reg_wr=1, reg_dst=1 and mem_to_reg=0.
- R7: A branch-equal walks addresses 1, 8, 0. Address 8 drives pc_wr_cond=1, alu_src_a=1, alu_src_b=00, alu_op=01 and pc_src=01.
- R8: A jump walks addresses 1, 9, 0. Address 9 drives pc_wr=1 and pc_src=10.
- R9: At decode, an opcode not listed in R3 sends the next address to 0.
- R10: At address 2, an opcode other than load or store sends the next address to 0.
- R11: mem_rd and mem_wr are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 6 | Instruction bits 31..26 |
| pc_wr_o | output | 1 | Unconditional PC write |
| pc_wr_cond_o | output | 1 | PC write when the ALU result is zero |
| iord_o | output | 1 | Memory address from ALU out (1) or PC (0) |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| ir_wr_o | output | 1 | Instruction register load |
| reg_wr_o | output | 1 | Register file write |
| reg_dst_o | output | 1 | Destination from rd (1) or rt (0) |
| mem_to_reg_o | output | 1 | Write data from memory (1) or ALU out (0) |
| alu_src_a_o | output | 1 | ALU A from register A (1) or PC (0) |
| alu_src_b_o | output | 2 | ALU B: 00 reg B, 01 four, 10 immediate, 11 shifted immediate |
| alu_op_o | output | 2 | 00 add, 01 subtract, 10 function field |
| pc_src_o | output | 2 | 00 ALU, 01 ALU out, 10 jump target |
| upc_o | output | 4 | Current microprogram address |

## Verification
The bench builds the block with its default widths: a 6-bit opcode and a 4-bit microprogram counter. With these widths all 64 opcode values can be swept, and each one is walked from fetch until it returns to fetch. Every cycle compares the whole control word and the next address against values computed in the bench. A second sweep changes the opcode while address 2 is active, so that the second lookup sees every opcode, including those that must fall back to fetch.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
  localparam int OP_W  = 6;
  localparam int UPC_W = 4;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OP_JUMP  = 6'h02;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE = 6'h2B;

  typedef enum logic [1:0] {
    SEQ_FETCH = 2'd0,
    SEQ_DISP1 = 2'd1,
    SEQ_DISP2 = 2'd2,
    SEQ_NEXT  = 2'd3
  } seq_e;

  typedef struct packed {
    logic wr;
    logic dst;
    logic mem_to_reg;
  } reg_f_t;

  typedef struct packed {
    logic rd;
    logic wr;
    logic iord;
    logic ir_wr;
  } mem_f_t;

  typedef struct packed {
    logic       wr;
    logic       wr_cond;
    logic [1:0] src;
  } pc_f_t;

  typedef struct packed {
    logic [1:0] alu_op;
    logic       src1;
    logic [1:0] src2;
    reg_f_t     regc;
    mem_f_t     mem;
    pc_f_t      pcc;
    seq_e       seq;
  } uword_t;
endpackage

// File: rtl/mc_ucode_rom.sv
module mc_ucode_rom
  import mc_ctrl_pkg::*;
#(
  parameter int AW = UPC_W
) (
  input  logic [AW-1:0] addr_i,
  output uword_t        word_o
);
  always_comb begin
    word_o     = '0;
    word_o.seq = SEQ_FETCH;
    case (addr_i)
      AW'(0): begin
        word_o.mem.rd    = 1'b1;
        word_o.mem.ir_wr = 1'b1;
        word_o.pcc.wr    = 1'b1;
        word_o.src2      = 2'b01;
        word_o.seq       = SEQ_NEXT;
      end
      AW'(1): begin
        word_o.src2 = 2'b11;
        word_o.seq  = SEQ_DISP1;
      end
      AW'(2): begin
        word_o.src1 = 1'b1;
        word_o.src2 = 2'b10;
        word_o.seq  = SEQ_DISP2;
      end
      AW'(3): begin
        word_o.mem.rd   = 1'b1;
        word_o.mem.iord = 1'b1;
        word_o.seq      = SEQ_NEXT;
      end
      AW'(4): begin
        word_o.regc.wr         = 1'b1;
        word_o.regc.mem_to_reg = 1'b1;
      end
      AW'(5): begin
        word_o.mem.wr   = 1'b1;
        word_o.mem.iord = 1'b1;
      end
      AW'(6): begin
        word_o.src1   = 1'b1;
        word_o.alu_op = 2'b10;
        word_o.seq    = SEQ_NEXT;
      end
      AW'(7): begin
        word_o.regc.wr  = 1'b1;
        word_o.regc.dst = 1'b1;
      end
      AW'(8): begin
        word_o.src1        = 1'b1;
        word_o.alu_op      = 2'b01;
        word_o.pcc.wr_cond = 1'b1;
        word_o.pcc.src     = 2'b01;
      end
      AW'(9): begin
        word_o.pcc.wr  = 1'b1;
        word_o.pcc.src = 2'b10;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mc_dispatch.sv
module mc_dispatch
  import mc_ctrl_pkg::*;
#(
  parameter int OW = OP_W,
  parameter int AW = UPC_W
) (
  input  logic [OW-1:0] opcode_i,
  output logic [AW-1:0] disp1_o,
  output logic [AW-1:0] disp2_o
);
  always_comb begin
    case (opcode_i)
      OP_RTYPE:          disp1_o = AW'(6);
      OP_JUMP:           disp1_o = AW'(9);
      OP_BEQ:            disp1_o = AW'(8);
      OP_LOAD, OP_STORE: disp1_o = AW'(2);
      default:           disp1_o = '0;
    endcase
  end

  always_comb begin
    case (opcode_i)
      OP_LOAD:  disp2_o = AW'(3);
      OP_STORE: disp2_o = AW'(5);
      default:  disp2_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_useq.sv
module mc_useq
  import mc_ctrl_pkg::*;
#(
  parameter int AW = UPC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  seq_e          seq_i,
  input  logic [AW-1:0] disp1_i,
  input  logic [AW-1:0] disp2_i,
  output logic [AW-1:0] upc_o
);
  logic [AW-1:0] upc_q, upc_d, upc_inc;

  assign upc_inc = upc_q + AW'(1);

  always_comb begin
    case (seq_i)
      SEQ_FETCH: upc_d = '0;
      SEQ_DISP1: upc_d = disp1_i;
      SEQ_DISP2: upc_d = disp2_i;
      default:   upc_d = upc_inc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upc_q <= '0;
    else         upc_q <= upc_d;
  end

  assign upc_o = upc_q;
endmodule

// File: rtl/mc_ctrl_seq.sv
module mc_ctrl_seq
  import mc_ctrl_pkg::*;
#(
  parameter int OW = OP_W,
  parameter int AW = UPC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [OW-1:0] opcode_i,
  output logic          pc_wr_o,
  output logic          pc_wr_cond_o,
  output logic          iord_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          ir_wr_o,
  output logic          reg_wr_o,
  output logic          reg_dst_o,
  output logic          mem_to_reg_o,
  output logic          alu_src_a_o,
  output logic [1:0]    alu_src_b_o,
  output logic [1:0]    alu_op_o,
  output logic [1:0]    pc_src_o,
  output logic [AW-1:0] upc_o
);
  uword_t        uw;
  logic [AW-1:0] upc, disp1, disp2;

  mc_useq #(.AW(AW)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seq_i  (uw.seq),
    .disp1_i(disp1),
    .disp2_i(disp2),
    .upc_o  (upc)
  );

  mc_ucode_rom #(.AW(AW)) u_rom (
    .addr_i(upc),
    .word_o(uw)
  );

  mc_dispatch #(.OW(OW), .AW(AW)) u_disp (
    .opcode_i(opcode_i),
    .disp1_o (disp1),
    .disp2_o (disp2)
  );

  assign pc_wr_o      = uw.pcc.wr;
  assign pc_wr_cond_o = uw.pcc.wr_cond;
  assign pc_src_o     = uw.pcc.src;
  assign iord_o       = uw.mem.iord;
  assign mem_rd_o     = uw.mem.rd;
  assign mem_wr_o     = uw.mem.wr;
  assign ir_wr_o      = uw.mem.ir_wr;
  assign reg_wr_o     = uw.regc.wr;
  assign reg_dst_o    = uw.regc.dst;
  assign mem_to_reg_o = uw.regc.mem_to_reg;
  assign alu_src_a_o  = uw.src1;
  assign alu_src_b_o  = uw.src2;
  assign alu_op_o     = uw.alu_op;
  assign upc_o        = upc;
endmodule

// File: rtl/mc_ctrl_seq_chk.sv
module mc_ctrl_seq_chk #(
  parameter int OW = 6,
  parameter int AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [OW-1:0] opcode_i,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic [AW-1:0] upc_o
);
  logic op_known;
  assign op_known = opcode_i inside {6'h00, 6'h02, 6'h04, 6'h23, 6'h2B};

  AST_RESET_ADDR: assert property (@(posedge clk_i) !rst_ni |=> upc_o == '0); // R1
  AST_FETCH_TO_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upc_o == AW'(0) |=> upc_o == AW'(1)); // R2
  AST_DECODE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_o == AW'(1) && opcode_i == 6'h23) |=> upc_o == AW'(2)); // R3
  AST_LOAD_READ_TO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upc_o == AW'(3) |=> upc_o == AW'(4)); // R4
  AST_STORE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upc_o == AW'(5) |=> upc_o == AW'(0)); // R5
  AST_RTYPE_EXEC_TO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upc_o == AW'(6) |=> upc_o == AW'(7)); // R6
  AST_BRANCH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upc_o == AW'(8) |=> upc_o == AW'(0)); // R7
  AST_JUMP_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upc_o == AW'(9) |=> upc_o == AW'(0)); // R8
  AST_UNKNOWN_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_o == AW'(1) && !op_known) |=> upc_o == AW'(0)); // R9
  AST_DISP2_FALLBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_o == AW'(2) && !(opcode_i inside {6'h23, 6'h2B})) |=> upc_o == AW'(0)); // R10
  AST_MEM_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R11
endmodule

bind mc_ctrl_seq mc_ctrl_seq_chk #(.OW(OW), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .opcode_i(opcode_i),
  .mem_rd_o(mem_rd_o),
  .mem_wr_o(mem_wr_o),
  .upc_o   (upc_o)
);

// File: tb/tb_mc_ctrl_seq.sv
module tb_mc_ctrl_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] opcode_i = '0;
  logic       pc_wr_o, pc_wr_cond_o, iord_o, mem_rd_o, mem_wr_o, ir_wr_o;
  logic       reg_wr_o, reg_dst_o, mem_to_reg_o, alu_src_a_o;
  logic [1:0] alu_src_b_o, alu_op_o, pc_src_o;
  logic [3:0] upc_o;
  int         n_tests = 0;
  int         n_fail  = 0;
  bit         done    = 1'b0;

  always #2 clk_i = ~clk_i;

  mc_ctrl_seq dut (.*);

  wire [15:0] cw = {pc_wr_o, pc_wr_cond_o, iord_o, mem_rd_o, mem_wr_o, ir_wr_o,
                    reg_wr_o, reg_dst_o, mem_to_reg_o, alu_src_a_o,
                    alu_src_b_o, alu_op_o, pc_src_o};

  function automatic logic [15:0] exp_cw(int s);
    case (s)
      0: return 16'h9410;
      1: return 16'h0030;
      2: return 16'h0060;
      3: return 16'h3000;
      4: return 16'h0280;
      5: return 16'h2800;
      6: return 16'h0048;
      7: return 16'h0300;
      8: return 16'h4045;
      9: return 16'h8002;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic int exp_next(int s, logic [5:0] op);
    case (s)
      0: return 1;
      1: return op == 6'h00 ? 6 : op == 6'h02 ? 9 : op == 6'h04 ? 8 :
                (op == 6'h23 || op == 6'h2B) ? 2 : 0;
      2: return op == 6'h23 ? 3 : op == 6'h2B ? 5 : 0;
      3: return 4;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2, 3, 4: return "R4";
      5: return "R5";
      6, 7: return "R6";
      8: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Walk one instruction from fetch back to fetch; op2 replaces opcode at address 2.
  task automatic walk(logic [5:0] op, logic [5:0] op2, string ntag);
    int s = 0;
    opcode_i = op;
    for (int c = 0; c < 8; c++) begin
      int nx;
      check($sformatf("%s state", tag_of(s)), int'(upc_o), s);
      check($sformatf("%s cw@%0d", tag_of(s), s), int'(cw), int'(exp_cw(s)));
      check("R11 mem excl", int'(mem_rd_o & mem_wr_o), 0);
      if (s == 2) opcode_i = op2;
      nx = exp_next(s, opcode_i);
      @(negedge clk_i);
      if (nx == 0) begin
        check($sformatf("%s return op=%0h", ntag, op), int'(upc_o), 0);
        break;
      end
      s = nx;
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset upc", int'(upc_o), 0);
    check("R1 reset cw", int'(cw), 16'h9410);
    @(posedge clk_i);
    check("R1 held upc", int'(upc_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int op = 0; op < 64; op++) begin
      logic [5:0] o = 6'(op);
      bit known = o inside {6'h00, 6'h02, 6'h04, 6'h23, 6'h2B};
      walk(o, o, known ? "R4" : "R9");
    end
    for (int op = 0; op < 64; op++) begin
      walk(6'h23, 6'(op), "R10");
      walk(6'h2B, 6'(op), "R10");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule